// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management side of one Ethernet PHY that sits behind a MAC's two management registers: a command register and a data register. Software writes a PHY address, a register number and a read/write flag into the command register. If the address equals the configured PHY address, the command runs at once against a small internal PHY register set. That set holds control, status, two identifier words, advertisement and link-partner abilities. A read command places the selected PHY register in the data register. A write command stores the low half of the data register into the selected PHY register.

There is no serial management wire. Each access completes on the clock edge that stores the command. The link input drives the link-up bit of the status register directly, so the status register always shows the current link state, including right after a PHY soft reset.

Command word layout: PHY address in bits [15:12], register number in bits [7:4], write flag in bit 1 (1 = write, 0 = read), busy flag in bit 0. The bus offsets are 0x48 for the command register and 0x4C for the data register.

The design has no sequencing state, so it contains no state machine. A command is classified combinationally into one of four kinds in the same cycle it is written:
- CK_NONE: no command this cycle.
- CK_FOREIGN: the PHY address does not match.
- CK_READ: matching read.
- CK_WRITE: matching write.

The clock edge at the end of that cycle performs the action for that kind.

Top module: `mgmt_phy_responder`

## Requirements
- R1: After reset, the command and data registers read 0, PHY control (register 0) reads 0x3100 and advertisement (register 4) reads 0x0000.
- R2: A bus write to offset 0x48 stores the written word with bit 0 (busy) forced to 0, and it reads back that way.
- R3: A bus write to offset 0x4C stores the word in the data register. Any offset other than 0x48 and 0x4C reads 0, and writes to such offsets change neither register.
- R4: A command whose bits [15:12] differ from the configured PHY address changes neither the data register nor any PHY register.
- R5: A matching write to register 0 with data bit 15 clear stores the data's low 16 bits with bits 15 and 9 forced to 0.
- R6: A matching write to register 0 with data bit 15 set returns control to 0x3100 and advertisement to 0. The link-up status bit still follows the link input.
- R7: Register 1 reads 0xFE28 with bit 2 set when the link input is 1, giving 0xFE2C.
- R8: Register 2 reads 0x0044, register 3 reads 0x1400 and register 5 reads 0x0DE0. Writes to registers 1, 2, 3 and 5 change nothing.
- R9: Register 4 is 16-bit read/write storage.
- R10: A matching read of any register number from 6 to 15 loads 0 into the data register.
- R11: A matching read command loads the data register on the same clock edge that stores the command, with the upper 16 bits zero. A write command leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W (8) | Register bus byte offset |
| bus_wdata | input | DATA_W (32) | Register bus write data |
| bus_rdata | output | DATA_W (32) | Register bus read data (combinational on bus_addr) |
| phy_addr_cfg | input | 4 | Configured PHY address |
| link_up | input | 1 | Link state reported in status bit 2 |

## Verification
Commands are driven with random register numbers across the full 0 to 15 range, random data, random link changes and occasional foreign PHY addresses. This separates three kinds of register: the stored ones (0 and 4), the fixed ones (1, 2, 3, 5) and the unknown ones that read as zero. Write data is chosen both with and without bit 15, so a soft reset of control and advertisement can be told apart from a masked store. Foreign-address commands and direct data-register writes placed between commands show whether the data register is overwritten only by matching reads.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    // Command word field positions
    localparam int PHY_AW       = 4;
    localparam int REG_NW       = 4;
    localparam int PHY_DW       = 16;
    localparam int CMD_PHY_LSB  = 12;
    localparam int CMD_REG_LSB  = 4;
    localparam int CMD_WR_BIT   = 1;
    localparam int CMD_BUSY_BIT = 0;

    // PHY register numbers
    localparam logic [REG_NW-1:0] PR_CTRL    = 4'd0;
    localparam logic [REG_NW-1:0] PR_STAT    = 4'd1;
    localparam logic [REG_NW-1:0] PR_ID_HI   = 4'd2;
    localparam logic [REG_NW-1:0] PR_ID_LO   = 4'd3;
    localparam logic [REG_NW-1:0] PR_ADV     = 4'd4;
    localparam logic [REG_NW-1:0] PR_PARTNER = 4'd5;

    // PHY register values and bit positions
    localparam int CTRL_SOFTRST_BIT = 15;
    localparam int CTRL_RENEG_BIT   = 9;
    localparam int STAT_LINK_BIT    = 2;
    localparam logic [PHY_DW-1:0] CTRL_DEFAULT = 16'h3100;
    localparam logic [PHY_DW-1:0] STAT_FIXED   = 16'hFE28;
    localparam logic [PHY_DW-1:0] ID_HI_VAL    = 16'h0044;
    localparam logic [PHY_DW-1:0] ID_LO_VAL    = 16'h1400;
    localparam logic [PHY_DW-1:0] PARTNER_VAL  = 16'h0DE0;
    localparam logic [PHY_DW-1:0] CTRL_WMASK   =
        ~((PHY_DW'(1) << CTRL_SOFTRST_BIT) | (PHY_DW'(1) << CTRL_RENEG_BIT));

    typedef enum logic [1:0] {
        CK_NONE,
        CK_FOREIGN,
        CK_READ,
        CK_WRITE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [REG_NW-1:0] regn;
    } phy_cmd_t;

endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
    import mgmt_phy_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CMD_OFS  = 'h48,
    parameter int DATA_OFS = 'h4C
) (
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PHY_AW-1:0] cmd_phy,
    input  logic [REG_NW-1:0] cmd_reg,
    input  logic              cmd_wr,
    input  logic [PHY_AW-1:0] phy_addr_cfg,
    output logic              cmd_we,
    output logic              data_we,
    output phy_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    always_comb begin
        cmd_we   = bus_wr_en && (bus_addr == CMD_A);
        data_we  = bus_wr_en && (bus_addr == DATA_A);
        cmd.regn = cmd_reg;
        if (!cmd_we) begin
            cmd.kind = CK_NONE;
        end else if (cmd_phy != phy_addr_cfg) begin
            cmd.kind = CK_FOREIGN;
        end else if (cmd_wr) begin
            cmd.kind = CK_WRITE;
        end else begin
            cmd.kind = CK_READ;
        end
    end

endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phy_cmd_t          cmd,
    input  logic [PHY_DW-1:0] wr_value,
    input  logic              link_up,
    output logic [PHY_DW-1:0] rd_value,
    output logic [PHY_DW-1:0] ctrl_q,
    output logic [PHY_DW-1:0] adv_q
);

    logic [PHY_DW-1:0] status_w;

    always_comb begin
        status_w = STAT_FIXED | (PHY_DW'(link_up) << STAT_LINK_BIT);
    end

    // Stored registers: control and advertisement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= '0;
        end else if (cmd.kind == CK_WRITE) begin
            unique case (cmd.regn)
                PR_CTRL: begin
                    if (wr_value[CTRL_SOFTRST_BIT]) begin
                        ctrl_q <= CTRL_DEFAULT;
                        adv_q  <= '0;
                    end else begin
                        ctrl_q <= wr_value & CTRL_WMASK;
                    end
                end
                PR_ADV:  adv_q <= wr_value;
                default: ;
            endcase
        end
    end

    // Read selection
    always_comb begin
        unique case (cmd.regn)
            PR_CTRL:    rd_value = ctrl_q;
            PR_STAT:    rd_value = status_w;
            PR_ID_HI:   rd_value = ID_HI_VAL;
            PR_ID_LO:   rd_value = ID_LO_VAL;
            PR_ADV:     rd_value = adv_q;
            PR_PARTNER: rd_value = PARTNER_VAL;
            default:    rd_value = '0;
        endcase
    end

endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
    import mgmt_phy_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CMD_OFS  = 'h48,
    parameter int DATA_OFS = 'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PHY_AW-1:0] phy_addr_cfg,
    input  logic              link_up
);

    localparam logic [ADDR_W-1:0] CMD_A     = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] DATA_A    = ADDR_W'(DATA_OFS);
    localparam logic [DATA_W-1:0] BUSY_MASK = ~(DATA_W'(1) << CMD_BUSY_BIT);

    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] data_q;
    logic [PHY_DW-1:0] ctrl_q;
    logic [PHY_DW-1:0] adv_q;
    logic [PHY_DW-1:0] phy_rd;
    logic              cmd_we;
    logic              data_we;
    phy_cmd_t          cmd;

    mgmt_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .CMD_OFS (CMD_OFS),
        .DATA_OFS(DATA_OFS)
    ) dec_i (
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .cmd_phy     (bus_wdata[CMD_PHY_LSB +: PHY_AW]),
        .cmd_reg     (bus_wdata[CMD_REG_LSB +: REG_NW]),
        .cmd_wr      (bus_wdata[CMD_WR_BIT]),
        .phy_addr_cfg(phy_addr_cfg),
        .cmd_we      (cmd_we),
        .data_we     (data_we),
        .cmd         (cmd)
    );

    mgmt_phy_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wr_value(data_q[PHY_DW-1:0]),
        .link_up (link_up),
        .rd_value(phy_rd),
        .ctrl_q  (ctrl_q),
        .adv_q   (adv_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_we) begin
                cmd_q <= bus_wdata & BUSY_MASK;
            end
            if (data_we) begin
                data_q <= bus_wdata;
            end else if (cmd.kind == CK_READ) begin
                data_q <= DATA_W'(phy_rd);
            end
        end
    end

    always_comb begin
        if (bus_addr == CMD_A) begin
            bus_rdata = cmd_q;
        end else if (bus_addr == DATA_A) begin
            bus_rdata = data_q;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/mgmt_phy_checker.sv
module mgmt_phy_checker
    import mgmt_phy_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CMD_OFS  = 'h48,
    parameter int DATA_OFS = 'h4C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [PHY_AW-1:0] phy_addr_cfg,
    input logic              link_up,
    input logic [DATA_W-1:0] cmd_q,
    input logic [DATA_W-1:0] data_q,
    input logic [PHY_DW-1:0] ctrl_q,
    input logic [PHY_DW-1:0] adv_q
);

    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    logic cmd_wr_c;
    logic match_c;
    assign cmd_wr_c = bus_wr_en && (bus_addr == CMD_A);
    assign match_c  = (bus_wdata[CMD_PHY_LSB +: PHY_AW] == phy_addr_cfg);

    // R2
    cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_c |=> cmd_q == ($past(bus_wdata) & ~(DATA_W'(1) << CMD_BUSY_BIT)));

    // R3
    data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == DATA_A) |=> data_q == $past(bus_wdata));

    // R4
    foreign_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_c && !match_c) |=> ($stable(data_q) && $stable(ctrl_q) && $stable(adv_q)));

    // R6
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_c && match_c && bus_wdata[CMD_WR_BIT]
         && bus_wdata[CMD_REG_LSB +: REG_NW] == PR_CTRL && data_q[CTRL_SOFTRST_BIT])
        |=> (ctrl_q == CTRL_DEFAULT && adv_q == '0));

    // R7
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_c && match_c && !bus_wdata[CMD_WR_BIT]
         && bus_wdata[CMD_REG_LSB +: REG_NW] == PR_STAT)
        |=> data_q == DATA_W'(STAT_FIXED | (PHY_DW'($past(link_up)) << STAT_LINK_BIT)));

    // R10
    unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_c && match_c && !bus_wdata[CMD_WR_BIT]
         && bus_wdata[CMD_REG_LSB +: REG_NW] > PR_PARTNER)
        |=> data_q == '0);

endmodule

bind mgmt_phy_responder mgmt_phy_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CMD_OFS (CMD_OFS),
    .DATA_OFS(DATA_OFS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .phy_addr_cfg(phy_addr_cfg),
    .link_up     (link_up),
    .cmd_q       (cmd_q),
    .data_q      (data_q),
    .ctrl_q      (ctrl_q),
    .adv_q       (adv_q)
);

// File: tb/mgmt_phy_responder_tb_top.sv
module mgmt_phy_responder_tb_top;

    localparam logic [7:0] A_CMD  = 8'h48;
    localparam logic [7:0] A_DATA = 8'h4C;
    localparam logic [3:0] CFG    = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  phy_addr_cfg = CFG;
    logic        link_up = 1'b0;

    always #10 clk = ~clk;

    mgmt_phy_responder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .phy_addr_cfg(phy_addr_cfg),
        .link_up     (link_up)
    );

    int total = 0;
    int bad   = 0;
    logic [15:0] m_ctrl = 16'h3100;
    logic [15:0] m_adv  = 16'h0000;
    logic [31:0] m_data = '0;
    bit          finished = 1'b0;

    function automatic logic [15:0] exp_phy(input logic [3:0] r, input logic lk);
        case (r)
            4'd0: return m_ctrl;
            4'd1: return 16'hFE28 | (lk ? 16'h0004 : 16'h0000);
            4'd2: return 16'h0044;
            4'd3: return 16'h1400;
            4'd4: return m_adv;
            4'd5: return 16'h0DE0;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] p, input logic [3:0] r, input logic w);
        if (p != CFG) return "R4";
        if (w) begin
            if (r == 4'd0) return "R5/R6";
            if (r == 4'd4) return "R9";
            return "R8/R11";
        end
        case (r)
            4'd0: return "R5";
            4'd1: return "R7";
            4'd2, 4'd3, 4'd5: return "R8";
            4'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = v;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_data(input logic [31:0] v);
        bus_wr(A_DATA, v);
        m_data = v;
    endtask

    // Issue a command, update the model, check data and command registers
    task automatic do_cmd(input logic [3:0] p, input logic [3:0] r, input logic w,
                          input logic [31:0] upper_noise);
        logic [31:0] word;
        logic [31:0] v;
        word = {upper_noise[31:16], p, upper_noise[11:8], r, upper_noise[3:2], w, 1'b1};
        bus_wr(A_CMD, word);
        if (p == CFG) begin
            if (w) begin
                if (r == 4'd0) begin
                    if (m_data[15]) begin
                        m_ctrl = 16'h3100;
                        m_adv  = 16'h0000;
                    end else begin
                        m_ctrl = m_data[15:0] & 16'h7DFF;
                    end
                end else if (r == 4'd4) begin
                    m_adv = m_data[15:0];
                end
            end else begin
                m_data = {16'h0000, exp_phy(r, link_up)};
            end
        end
        bus_rd(A_DATA, v);
        check(tag_of(p, r, w), v, m_data);
        bus_rd(A_CMD, v);
        check("R2", v, word & 32'hFFFF_FFFE);
    endtask

    task automatic summary_and_end;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        summary_and_end();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(A_CMD, v);
        check("R1", v, 32'h0);
        bus_rd(A_DATA, v);
        check("R1", v, 32'h0);
        do_cmd(CFG, 4'd0, 1'b0, 32'h0);
        check("R1", m_data, 32'h3100);
        do_cmd(CFG, 4'd4, 1'b0, 32'h0);
        check("R1", m_data, 32'h0);

        // R3 other offsets read zero and writes there change nothing
        set_data(32'hCAFE_F00D);
        bus_wr(8'h50, 32'hFFFF_FFFF);
        bus_rd(8'h50, v);
        check("R3", v, 32'h0);
        bus_rd(A_DATA, v);
        check("R3", v, 32'hCAFE_F00D);

        // R5 masked store into control
        set_data(32'h0000_7FFF);
        do_cmd(CFG, 4'd0, 1'b1, 32'h0);
        do_cmd(CFG, 4'd0, 1'b0, 32'h0);
        check("R5", m_data, 32'h0000_7DFF);

        // R9 advertisement storage
        set_data(32'hFFFF_A5A5);
        do_cmd(CFG, 4'd4, 1'b1, 32'h0);
        do_cmd(CFG, 4'd4, 1'b0, 32'h0);
        check("R9", m_data, 32'h0000_A5A5);

        // R6 soft reset keeps link state
        link_up = 1'b1;
        set_data(32'h0000_8000);
        do_cmd(CFG, 4'd0, 1'b1, 32'h0);
        do_cmd(CFG, 4'd0, 1'b0, 32'h0);
        check("R6", m_data, 32'h3100);
        do_cmd(CFG, 4'd4, 1'b0, 32'h0);
        check("R6", m_data, 32'h0);
        do_cmd(CFG, 4'd1, 1'b0, 32'h0);
        check("R6", m_data, 32'hFE2C);

        // R7 link follows input
        @(negedge clk) link_up = 1'b0;
        do_cmd(CFG, 4'd1, 1'b0, 32'h0);
        check("R7", m_data, 32'hFE28);

        // R8 fixed registers ignore writes
        set_data(32'h0000_FFFF);
        do_cmd(CFG, 4'd1, 1'b1, 32'h0);
        do_cmd(CFG, 4'd2, 1'b1, 32'h0);
        do_cmd(CFG, 4'd3, 1'b1, 32'h0);
        do_cmd(CFG, 4'd5, 1'b1, 32'h0);
        do_cmd(CFG, 4'd2, 1'b0, 32'h0);
        check("R8", m_data, 32'h0044);
        do_cmd(CFG, 4'd3, 1'b0, 32'h0);
        check("R8", m_data, 32'h1400);
        do_cmd(CFG, 4'd5, 1'b0, 32'h0);
        check("R8", m_data, 32'h0DE0);

        // R10 unknown registers read zero
        do_cmd(CFG, 4'd9, 1'b0, 32'h0);
        check("R10", m_data, 32'h0);
        do_cmd(CFG, 4'd15, 1'b0, 32'h0);
        check("R10", m_data, 32'h0);

        // R4 foreign address
        set_data(32'h0000_BEEF);
        do_cmd(4'h3, 4'd2, 1'b0, 32'h0);
        check("R4", m_data, 32'h0000_BEEF);
        do_cmd(4'h3, 4'd4, 1'b1, 32'h0);
        do_cmd(CFG, 4'd4, 1'b0, 32'h0);
        check("R4", m_data, 32'h0);

        // R11 write command leaves data register alone
        set_data(32'h1234_0123);
        do_cmd(CFG, 4'd4, 1'b1, 32'hFFFF_FFFF);
        check("R11", m_data, 32'h1234_0123);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 4;
            if (op == 0) begin
                set_data($urandom);
                bus_rd(A_DATA, v);
                check("R3", v, m_data);
            end else if (op == 1) begin
                @(negedge clk) link_up = $urandom % 2;
            end else begin
                logic [3:0] p;
                p = ($urandom % 4 == 0) ? 4'($urandom) : CFG;
                do_cmd(p, 4'($urandom), 1'($urandom), $urandom);
            end
        end

        summary_and_end();
    end

endmodule